// File: doc/BRIEF.md
# Programmable-ratio sinc3 decimator

This block is a third-order cascaded integrator-comb decimator for a sigma-delta ADC channel. It takes signed raw converter codes, one per strobe of `in_valid`, and emits one filtered word for every R input samples. R is chosen by a two-bit rate field. The result is the sum of the recent inputs weighted by the sinc3 kernel, which is three length-R boxcars convolved together, so the DC gain is R³. The strobe usually arrives once every 20 clocks, but any spacing works.

A bypass input sends the raw codes straight through without filtering. A synchronous `flush` clears every integrator, comb delay, phase counter and settling counter. Software must pulse `flush` whenever it changes the rate or the analog channel, because outputs computed across such a change are wrong. After every flush, reset or exit from bypass, the first two decimated words are withheld while the comb stages fill. `rd_data` keeps the most recent result until the next one arrives.

Top module: `cic3_decim`

## Requirements
- R1: `rate_sel` sets R as follows: 2'b00 gives 5, 2'b01 gives 4, 2'b10 gives 2, and the reserved 2'b11 gives 4. In filter mode, an output is due on every R-th accepted sample counted since the last clear.
- R2: Let n be the index of the sample that completes a group, counted from 0 since the last clear. The output word is the sum of h[k]·x[n−k] for k = 0 … 3R−3. Here h[k] is the number of triples (a,b,c) in [0,R−1]³ with a+b+c=k, and samples from before the clear count as zero.
- R3: `out_valid` is a one-cycle pulse in the cycle after the accepted sample that completes a group. It is never high unless `in_valid` was high in the previous cycle. `out_data` is zero whenever `out_valid` is low.
- R4: While `bypass` is 1, each accepted sample appears sign-extended on `out_data`, with `out_valid`, in the next cycle. During bypass the filter state is held cleared.
- R5: A `flush` pulse clears all filter state and the sample phase, and no output appears in the cycle after it. The next sample starts a new group, and older samples no longer contribute.
- R6: `rd_data` takes each emitted word and holds it unchanged until the next one.
- R7: After a reset, a flush or leaving bypass, the first two group completions produce no output. The third completion, at sample index 3R−1, produces the first output.
- R8: The integrators wrap in two's complement at `IN_W + 3*ceil(log2(MAX_R))` bits. Long full-scale runs still give exact outputs.
- R9: After reset, `out_valid` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous soft clear of filter state |
| bypass | input | 1 | 1: pass raw codes, 0: sinc3 path |
| rate_sel | input | 2 | Decimation ratio select |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed raw ADC code |
| out_valid | output | 1 | Output word strobe |
| out_data | output | ACC_W | Signed output word, zero when not valid |
| rd_data | output | ACC_W | Latest result, held |

## Verification
The filter is driven with a DC level, a single impulse, a ramp and an alternating full-swing tone under every rate code. The DC level confirms the R³ gain. The impulse traces the kernel shape tap by tap. The ramp separates a correct group phase from a phase that is off by one. The alternating tone exposes sign errors in the comb. A long full-scale negative run forces the integrators to wrap and shows the outputs stay exact. Directed sequences cover bypass echo, a flush in the middle of a group, and the suppression of the first two outputs after leaving bypass.

// File: rtl/cic3_pkg.sv
package cic3_pkg;

    localparam int DEF_IN_W  = 16;
    localparam int DEF_MAX_R = 5;
    localparam int ORDER     = 3;

    typedef enum logic [1:0] {
        RATE_5   = 2'b00,
        RATE_4   = 2'b01,
        RATE_2   = 2'b10,
        RATE_RSV = 2'b11
    } rate_sel_e;

    function automatic int acc_width(int in_w, int max_r);
        return in_w + ORDER * $clog2(max_r);
    endfunction

    function automatic int ratio_of(rate_sel_e s);
        case (s)
            RATE_5:  return 5;
            RATE_2:  return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/cic3_phase.sv
module cic3_phase
    import cic3_pkg::*;
#(
    parameter int MAX_R = DEF_MAX_R,
    localparam int CW   = $clog2(MAX_R + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          in_valid,
    input  logic [CW-1:0] ratio,
    output logic          strike,
    output logic          settled
);

    logic [CW-1:0] cnt_q;
    logic [1:0]    settle_q;

    assign strike  = in_valid && !clr && (cnt_q >= ratio - CW'(1));
    assign settled = (settle_q == 2'd2);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q    <= '0;
            settle_q <= '0;
        end else if (in_valid) begin
            cnt_q <= strike ? '0 : cnt_q + CW'(1);
            if (strike && settle_q != 2'd2)
                settle_q <= settle_q + 2'd1;
        end
    end

    // R5: a clear empties the phase and settling counts
    p_phase_clear_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0 && settle_q == 2'd0));

    // R7: settling progress only goes back on a clear
    p_settle_mono_r7: assert property (@(posedge clk) disable iff (rst)
        (settle_q != 2'd0 && !clr) |=> (settle_q >= $past(settle_q)));

endmodule

// File: rtl/cic3_integ.sv
module cic3_integ
    import cic3_pkg::*;
#(
    parameter int IN_W  = DEF_IN_W,
    parameter int ACC_W = acc_width(DEF_IN_W, DEF_MAX_R)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  x,
    output logic signed [ACC_W-1:0] sum_nxt
);

    logic signed [ACC_W-1:0] acc_q [ORDER];
    logic signed [ACC_W-1:0] chain [ORDER+1];

    assign chain[0] = {{(ACC_W-IN_W){x[IN_W-1]}}, x};

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        assign chain[g+1] = acc_q[g] + chain[g];
        always_ff @(posedge clk) begin
            if (clr)
                acc_q[g] <= '0;
            else if (en)
                acc_q[g] <= chain[g+1];
        end
    end

    assign sum_nxt = chain[ORDER];

    // R5: a clear empties every integrator
    p_integ_clear_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q[0] == '0 && acc_q[ORDER-1] == '0));

endmodule

// File: rtl/cic3_comb.sv
module cic3_comb
    import cic3_pkg::*;
#(
    parameter int ACC_W = acc_width(DEF_IN_W, DEF_MAX_R)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] x,
    output logic signed [ACC_W-1:0] y
);

    logic signed [ACC_W-1:0] dly_q [ORDER];
    logic signed [ACC_W-1:0] diff  [ORDER+1];

    assign diff[0] = x;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        assign diff[g+1] = diff[g] - dly_q[g];
        always_ff @(posedge clk) begin
            if (clr)
                dly_q[g] <= '0;
            else if (en)
                dly_q[g] <= diff[g];
        end
    end

    assign y = diff[ORDER];

    // R1: comb delays move only on a group completion
    p_comb_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(dly_q[0]));

endmodule

// File: rtl/cic3_decim.sv
module cic3_decim
    import cic3_pkg::*;
#(
    parameter int IN_W   = DEF_IN_W,
    parameter int MAX_R  = DEF_MAX_R,
    localparam int ACC_W = acc_width(IN_W, MAX_R),
    localparam int CW    = $clog2(MAX_R + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             bypass,
    input  logic [1:0]       rate_sel,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_data,
    output logic [ACC_W-1:0] rd_data
);

    logic                    clr;
    logic [CW-1:0]           ratio;
    logic                    strike;
    logic                    settled;
    logic                    emit;
    logic signed [ACC_W-1:0] integ_sum;
    logic signed [ACC_W-1:0] comb_out;
    logic        [ACC_W-1:0] raw_ext;

    assign clr     = rst || flush || bypass;
    assign ratio   = CW'(ratio_of(rate_sel_e'(rate_sel)));
    assign raw_ext = {{(ACC_W-IN_W){in_data[IN_W-1]}}, in_data};

    cic3_phase #(.MAX_R(MAX_R)) u_phase (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .ratio(ratio), .strike(strike), .settled(settled)
    );

    cic3_integ #(.IN_W(IN_W), .ACC_W(ACC_W)) u_integ (
        .clk(clk), .rst(rst), .clr(clr), .en(in_valid),
        .x(in_data), .sum_nxt(integ_sum)
    );

    cic3_comb #(.ACC_W(ACC_W)) u_comb (
        .clk(clk), .rst(rst), .clr(clr), .en(strike),
        .x(integ_sum), .y(comb_out)
    );

    assign emit = strike && settled;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            rd_data   <= '0;
        end else if (bypass) begin
            out_valid <= in_valid;
            out_data  <= in_valid ? raw_ext : '0;
            if (in_valid)
                rd_data <= raw_ext;
        end else begin
            out_valid <= emit;
            out_data  <= emit ? comb_out : '0;
            if (emit)
                rd_data <= comb_out;
        end
    end

    // R4: bypass echoes the sample, sign-extended, one cycle later
    p_bypass_echo_r4: assert property (@(posedge clk) disable iff (rst)
        (bypass && in_valid) |=> (out_valid &&
            out_data == {{(ACC_W-IN_W){$past(in_data[IN_W-1])}}, $past(in_data)}));

    // R6: the held register agrees with every emitted word
    p_rd_tracks_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (rd_data == out_data));

    // R3: no output without an accepted sample the cycle before
    p_out_needs_in_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R5: a flush in filter mode silences the next cycle
    p_flush_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (flush && !bypass) |=> !out_valid);

endmodule

// File: tb/cic3_decim_test.sv
module cic3_decim_test;
    import cic3_pkg::*;

    localparam int IN_W  = 16;
    localparam int MAX_R = 5;
    localparam int ACC_W = acc_width(IN_W, MAX_R);

    typedef struct packed {
        logic [1:0] sel;
        logic [2:0] kind;
        logic [7:0] nsamp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 8'd30},
        '{2'd1, 3'd1, 8'd24},
        '{2'd2, 3'd2, 8'd20},
        '{2'd3, 3'd3, 8'd24},
        '{2'd0, 3'd3, 8'd30},
        '{2'd2, 3'd1, 8'd16},
        '{2'd0, 3'd4, 8'd60},
        '{2'd1, 3'd2, 8'd28},
        '{2'd3, 3'd0, 8'd20}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             flush = 1'b0;
    logic             bypass = 1'b0;
    logic [1:0]       rate_sel = 2'b00;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic             out_valid;
    logic [ACC_W-1:0] out_data;
    logic [ACC_W-1:0] rd_data;

    cic3_decim uut (
        .clk(clk), .rst(rst), .flush(flush), .bypass(bypass),
        .rate_sel(rate_sel), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    int      total = 0;
    int      bad = 0;
    bit      done = 1'b0;
    longint  hist [256];
    int      nhist = 0;
    int      cur_r = 5;
    string   cur_tag = "R2";
    logic [ACC_W-1:0] last_out = '0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio_for(input logic [1:0] s);
        case (s)
            2'b00:   return 5;
            2'b10:   return 2;
            default: return 4;
        endcase
    endfunction

    function automatic int tap(input int r, input int k);
        int c = 0;
        for (int a = 0; a < r; a++)
            for (int b = 0; b < r; b++)
                if (k - a - b >= 0 && k - a - b < r) c++;
        return c;
    endfunction

    function automatic longint model(input int n, input int r);
        longint s = 0;
        for (int k = 0; k <= 3*r - 3; k++)
            if (n - k >= 0) s += longint'(tap(r, k)) * hist[n-k];
        return s;
    endfunction

    function automatic longint pat(input int kind, input int i);
        case (kind)
            0:       return 1000;
            1:       return (i == 7) ? 20000 : 0;
            2:       return longint'(i) * 300 - 9000;
            3:       return (i % 2 == 1) ? 12345 : -12345;
            default: return -32768;
        endcase
    endfunction

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check(out_valid == 1'b0, "R5", longint'(out_valid), 0);
        nhist = 0;
    endtask

    task automatic send_filt(input longint x);
        bit exp_v;
        logic signed [ACC_W-1:0] e;
        in_data  = IN_W'(x);
        in_valid = 1'b1;
        hist[nhist] = x;
        @(negedge clk);
        in_valid = 1'b0;
        exp_v = ((nhist + 1) % cur_r == 0) && ((nhist + 1) / cur_r >= 3);
        if ((nhist + 1) % cur_r == 0 && !exp_v)
            check(out_valid == 1'b0, "R7", longint'(out_valid), 0);
        else
            check(out_valid == exp_v, "R1", longint'(out_valid), longint'(exp_v));
        if (exp_v) begin
            e = ACC_W'(model(nhist, cur_r));
            check(out_data == e, cur_tag, longint'($signed(out_data)), longint'(e));
            last_out = e;
        end
        nhist++;
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R3", longint'(out_data), 0);
        repeat (17) @(negedge clk);
        check(rd_data == last_out, "R6", longint'($signed(rd_data)), longint'($signed(last_out)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0, "R9", longint'(out_valid), 0);
        check(rd_data == '0, "R9", longint'(rd_data), 0);

        // R1 R2 R7 R8: table of rate codes and input patterns
        for (int v = 0; v < NV; v++) begin
            rate_sel = VECS[v].sel;
            cur_r    = ratio_for(VECS[v].sel);
            cur_tag  = (VECS[v].kind == 3'd4) ? "R8" : "R2";
            do_flush();
            for (int i = 0; i < int'(VECS[v].nsamp); i++)
                send_filt(pat(int'(VECS[v].kind), i));
        end
        cur_tag = "R2";

        // R4: bypass echoes raw codes with sign extension
        bypass = 1'b1;
        for (int i = 0; i < 4; i++) begin
            logic signed [ACC_W-1:0] e;
            longint x = (i % 2 == 0) ? -longint'(1000 + i) : longint'(31000 + i);
            e = ACC_W'(x);
            in_data  = IN_W'(x);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check(out_valid == 1'b1 && out_data == e, "R4",
                  longint'($signed(out_data)), longint'(e));
            last_out = e;
            repeat (5) @(negedge clk);
            check(rd_data == e, "R6", longint'($signed(rd_data)), longint'(e));
        end

        // R7: leaving bypass restarts settling
        bypass   = 1'b0;
        rate_sel = 2'b10;
        cur_r    = 2;
        nhist    = 0;
        @(negedge clk);
        for (int i = 0; i < 8; i++) send_filt(longint'(700 - 150 * i));

        // R5: flush mid-group drops earlier samples and phase
        rate_sel = 2'b10;
        cur_r    = 2;
        do_flush();
        for (int i = 0; i < 13; i++) send_filt(longint'(5000 + 10 * i));
        do_flush();
        cur_tag = "R5";
        for (int i = 0; i < 8; i++) send_filt((i < 6) ? 0 : 2222);
        cur_tag = "R2";

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule